// File: doc/BRIEF.md
# Dual-Channel Compare Toggle Timer

A free-running up-counter shared by a set of compare channels, two by default. Each channel owns a compare register and one output pin. In toggle mode a channel flips its pin on every counting cycle in which the count equals its compare value, so the pin is a square wave whose edges sit at chosen counter phases. A per-channel enable chooses between the toggling level and a fixed idle level. A per-channel level-select bit picks that idle level. A run bit starts and stops the counter, and stopping it freezes every pin at its current level.

Software reaches all state through a synchronous parallel write port. Word 0 is the control word. Word 1 is the count. Words 2 and up are the compare registers, one per channel. The count is visible on an output so the host can follow the counter phase.

Top module: `cmp_toggle_timer`

## Requirements
- R1: While the run bit (control bit 0) is 1, the count rises by one per clock and wraps from all ones (FFFFh) to 0.
- R2: While the run bit is 0, the count holds its value.
- R3: A write to address 1 loads the count on that edge and takes priority over the increment. Writes to address 2+n load the compare register of channel n.
- R4: In toggle mode (control bits [2:1] = 01), for an enabled channel (control bit 3+n = 1), a cycle with run = 1 and count equal to compare n inverts pin n from the next cycle on. The channels act independently.
- R5: A channel with its enable bit at 0 drives its fixed level: high when its level-select bit (control bit 3+NCH+n) is 0, and low when it is 1.
- R6: When a channel turns active, its toggling level starts from the fixed level it was driving, so the first match drives the opposite level.
- R7: While the run bit is 0 and no register is written, every pin keeps its level.
- R8: No match is seen while the counter is stopped, even when a compare value is written equal to the stopped count.
- R9: Any mode code other than 01 holds every pin at its fixed level.
- R10: A synchronous reset clears the count, the compare registers and the control word, so every pin comes out of reset high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (2) | Word select: 0 control, 1 count, 2+n compare n |
| wr_data | input | CNT_W (16) | Write data |
| count_out | output | CNT_W (16) | Current count |
| pin_out | output | NCH (2) | Channel output pins |

## Verification
The bench moves the count across the wrap from FFFFh to 0 and checks that a later match still toggles. If the wrap were wrong, the count would stall or the toggle would land in the wrong phase. It stops the counter, then writes a compare value equal to the frozen count. A design that matched while stopped would flip a pin that must stay frozen. It leaves toggle mode and returns to it. A design that did not reload the toggle state from the fixed level would resume at a stale level. It also loads the count while running, where a design that let the increment win would show the loaded value plus one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_TOGGLE = 2'b01,
      MODE_RSV_A  = 2'b10,
      MODE_RSV_B  = 2'b11
   } tmr_mode_e;

   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_MODE_LO = 1;
   localparam int unsigned CTRL_EN_LO   = 3;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (rst)       count <= '0;
      else if (load) count <= load_val;
      else if (run)  count <= count + 1'b1;
   end

   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      (run && !load) |=> (count == $past(count) + 1'b1));
   a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
      (run && !load && (&count)) |=> (count == '0));
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (!run && !load) |=> $stable(count));
   a_r3_load: assert property (@(posedge clk) disable iff (rst)
      load |=> (count == $past(load_val)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NCH    = 2,
   parameter int unsigned ADDR_W = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [CNT_W-1:0]           wr_data,
   output logic [CNT_W-1:0]           ctrl,
   output logic [NCH-1:0][CNT_W-1:0]  cmp,
   output logic                       cnt_load
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);

   assign cnt_load = wr_en && (wr_addr == A_CNT);

   always_ff @(posedge clk) begin
      if (rst)                                ctrl <= '0;
      else if (wr_en && (wr_addr == A_CTRL))  ctrl <= wr_data;
   end

   for (genvar n = 0; n < NCH; n++) begin : g_cmp
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(n + 2);
      always_ff @(posedge clk) begin
         if (rst)                               cmp[n] <= '0;
         else if (wr_en && (wr_addr == A_CMP))  cmp[n] <= wr_data;
      end
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             toggle_mode,
   input  logic             ch_en,
   input  logic             lvl_sel,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             pin
);
   logic fixed_lvl;
   logic active;
   logic hit;
   logic tgl_q;

   assign fixed_lvl = ~lvl_sel;
   assign active    = toggle_mode && ch_en;
   assign hit       = run && (count == cmp_val);

   always_ff @(posedge clk) begin
      if (rst)          tgl_q <= 1'b1;
      else if (!active) tgl_q <= fixed_lvl;
      else if (hit)     tgl_q <= ~tgl_q;
   end

   assign pin = active ? tgl_q : fixed_lvl;

   a_r4_flip: assert property (@(posedge clk) disable iff (rst)
      (active && hit) |=> (tgl_q != $past(tgl_q)));
   a_r6_seed: assert property (@(posedge clk) disable iff (rst)
      !active |=> (tgl_q == $past(fixed_lvl)));
   a_r8_no_hit: assert property (@(posedge clk) disable iff (rst)
      (active && !run) |=> $stable(tgl_q));
endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NCH    = 2,
   parameter int unsigned ADDR_W = $clog2(NCH + 2)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count_out,
   output logic [NCH-1:0]    pin_out
);
   localparam int unsigned LVL_LO   = CTRL_EN_LO + NCH;
   localparam int unsigned CTRL_TOP = LVL_LO + NCH;

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end
   if (CTRL_TOP > CNT_W) begin : g_bad_ctrl
      $error("control fields do not fit in CNT_W");
   end
   if ((1 << ADDR_W) < NCH + 2) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [CNT_W-1:0]          ctrl;
   logic [NCH-1:0][CNT_W-1:0] cmp;
   logic                      cnt_load;
   logic                      run;
   logic                      toggle_mode;
   tmr_mode_e                 mode;

   tmr_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ctrl     (ctrl),
      .cmp      (cmp),
      .cnt_load (cnt_load)
   );

   assign run         = ctrl[CTRL_RUN_BIT];
   assign mode        = tmr_mode_e'(ctrl[CTRL_MODE_LO +: 2]);
   assign toggle_mode = (mode == MODE_TOGGLE);

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .load     (cnt_load),
      .load_val (wr_data),
      .count    (count_out)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      tmr_chan #(.CNT_W(CNT_W)) u_ch (
         .clk         (clk),
         .rst         (rst),
         .run         (run),
         .toggle_mode (toggle_mode),
         .ch_en       (ctrl[CTRL_EN_LO + n]),
         .lvl_sel     (ctrl[LVL_LO + n]),
         .count       (count_out),
         .cmp_val     (cmp[n]),
         .pin         (pin_out[n])
      );

      a_r5_idle: assert property (@(posedge clk) disable iff (rst)
         !ctrl[CTRL_EN_LO + n] |-> (pin_out[n] == ~ctrl[LVL_LO + n]));
      a_r9_mode: assert property (@(posedge clk) disable iff (rst)
         !toggle_mode |-> (pin_out[n] == ~ctrl[LVL_LO + n]));
   end

   a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
      (!run && !wr_en) |=> $stable(pin_out));
   a_r10_reset: assert property (@(posedge clk)
      $past(rst) |-> ((count_out == '0) && (&pin_out)));
endmodule

// File: tb/tb_cmp_toggle_timer.sv
module tb_cmp_toggle_timer;
   localparam int CNT_W = 16;
   localparam int NCH   = 2;
   localparam int AW    = 2;
   localparam int NROW  = 22;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [CNT_W-1:0] count_out;
   logic [NCH-1:0]   pin_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cmp_toggle_timer #(.CNT_W(CNT_W), .NCH(NCH)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count_out(count_out), .pin_out(pin_out)
   );

   // row: {write?, addr, data-or-cycles, expected count, expected pins}
   // control: bit0 run, [2:1] mode (01 toggle), [4:3] enables, [6:5] level selects
   localparam logic [36:0] VEC [NROW] = '{
      {1'b1, 2'd2, 16'h0005, 16'h0000, 2'b11},
      {1'b1, 2'd3, 16'h0008, 16'h0000, 2'b11},
      {1'b1, 2'd0, 16'h0022, 16'h0000, 2'b10},
      {1'b1, 2'd0, 16'h003B, 16'h0000, 2'b10},
      {1'b0, 2'd0, 16'd5,    16'h0005, 2'b10},
      {1'b0, 2'd0, 16'd1,    16'h0006, 2'b11},
      {1'b0, 2'd0, 16'd2,    16'h0008, 2'b11},
      {1'b0, 2'd0, 16'd1,    16'h0009, 2'b01},
      {1'b1, 2'd0, 16'h003D, 16'h000A, 2'b10},
      {1'b1, 2'd0, 16'h003B, 16'h000B, 2'b10},
      {1'b1, 2'd1, 16'hFFFE, 16'hFFFE, 2'b10},
      {1'b0, 2'd0, 16'd1,    16'hFFFF, 2'b10},
      {1'b0, 2'd0, 16'd1,    16'h0000, 2'b10},
      {1'b0, 2'd0, 16'd6,    16'h0006, 2'b11},
      {1'b1, 2'd0, 16'h003A, 16'h0007, 2'b11},
      {1'b0, 2'd0, 16'd3,    16'h0007, 2'b11},
      {1'b1, 2'd3, 16'h0007, 16'h0007, 2'b11},
      {1'b0, 2'd0, 16'd2,    16'h0007, 2'b11},
      {1'b1, 2'd0, 16'h003B, 16'h0007, 2'b11},
      {1'b0, 2'd0, 16'd1,    16'h0008, 2'b01},
      {1'b1, 2'd0, 16'h0033, 16'h0009, 2'b00},
      {1'b0, 2'd0, 16'd1,    16'h000A, 2'b00}
   };

   function automatic string row_tag(int i);
      case (i)
         0, 1:         return "R3 compare load";
         2:            return "R5 idle level";
         3, 4:         return "R6 seed from idle";
         5, 6, 7:      return "R4 toggle";
         8:            return "R9 reserved mode";
         9:            return "R6 reseed";
         10:           return "R3 count load wins";
         11, 12:       return "R1 wrap";
         13:           return "R4 toggle after wrap";
         14, 15:       return "R7 R2 stopped";
         16, 17, 18:   return "R8 no match stopped";
         19:           return "R4 channel 1";
         default:      return "R5 disable";
      endcase
   endfunction

   task automatic check(string tag, logic [CNT_W-1:0] ec, logic [NCH-1:0] ep);
      total++;
      if (count_out !== ec || pin_out !== ep) begin
         bad++;
         $display("FAIL %s: count=%h pins=%b expected count=%h pins=%b",
                  tag, count_out, pin_out, ec, ep);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [CNT_W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: expired, expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R10 reset state", 16'h0000, 2'b11);

      for (int i = 0; i < NROW; i++) begin
         if (VEC[i][36]) wr(VEC[i][35:34], VEC[i][33:18]);
         else repeat (int'(VEC[i][33:18])) @(negedge clk);
         check(row_tag(i), VEC[i][17:2], VEC[i][1:0]);
      end

      // R10: reset while running
      wr(2'd0, 16'h003B);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      check("R10 mid-run reset", 16'h0000, 2'b11);
      @(negedge clk);
      check("R10 control cleared, count held", 16'h0000, 2'b11);

      // R5: both level selects set, both disabled -> both low
      wr(2'd0, 16'h0060);
      check("R5 low idle", 16'h0000, 2'b00);

      // R6: channel 1 idle low, then enabled; first match drives high
      wr(2'd3, 16'h0003);
      wr(2'd0, 16'h0073);
      check("R6 enabled stays at idle", 16'h0000, 2'b00);
      repeat (3) @(negedge clk);
      check("R6 before match", 16'h0003, 2'b00);
      @(negedge clk);
      check("R6 first match", 16'h0004, 2'b10);

      finish_run();
   end
endmodule